// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that gives an external controller access to a small bank of 8-bit configuration registers. The registers drive the rest of the chip in parallel through a flat output bus. They load fixed default values at reset, so a system that never talks to the slave still gets a working configuration. The slave runs from a fast system clock. It oversamples SCL and SDA through two-flop synchronizers and pulls SDA low through an open-drain output enable.

After the address byte the controller sends a command byte. Its top bit picks the access type. When the bit is set the access is indexed and single-byte, and the low five bits name the register. When the bit is clear the access is a block that always starts at register 0. Block writes carry a byte count ahead of the data. Block reads answer with the byte count first and then the registers in ascending order. A read is started with a repeated start after the command. Start and stop conditions are recognized at any bit position and reset the protocol engine.

Top module: `smb_reg_slave`

## Requirements
- R1: At reset `regs_o` holds the defaults, register k in bits [8k+7:8k]: r0=0x07, r1=0xFF, r2=0x81, r3=0x00, r4=0x3C, r5=0xA5, r6=0x00, r7=0x0F. `sda_oe_o` is 0.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address is NACKed and the rest of the transaction is ignored: no further ACK and no register change.
- R3: Command bit 7 selects byte access (1) or block access (0). Command bits 6:5 must be 00, otherwise the command and all following bytes are NACKed and ignored.
- R4: In a byte write (command 0x80|k, one data byte) the data lands in register k, and every byte is ACKed. An offset k of 8 or more is NACKed at the command byte and changes nothing.
- R5: A byte read (address 0xD2, command 0x80|k, repeated start, address 0xD3) returns register k MSB first.
- R6: A block write (command 0x00, count N, data bytes) stores byte i in register i for i < min(N, 8). Bytes beyond N or beyond register 7 are ACKed and discarded. A stop after any complete byte keeps the bytes already stored.
- R7: A block read (command 0x00, repeated start, address 0xD3) returns the count 0x08 first and then registers 0 to 7. After the controller NACKs a byte, the slave releases SDA.
- R8: The slave changes SDA only while SCL is low. A start or a stop at any bit position aborts the byte in progress. A stop in mid-byte writes nothing, and a start in mid-byte begins a fresh address phase.
- R9: An address 0xD3 that is not preceded, in the same transaction, by an accepted command is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | 64 | Register bank, register k in bits [8k+7:8k] |

## Verification
The assertions check on every cycle four things. The slave asserts SDA only while SCL is low. A register changes only in the cycle after an accepted write, and that write is acknowledged. The slave stays off the line while idle or ignoring a transaction. Every start sends the engine to the address phase and every stop sends it to idle. Only the bench scenarios can show what happens byte by byte: which bytes are ACKed or NACKed for each address and command, the values returned by byte and block reads, the count byte, and the treatment of extra, discarded and aborted bytes.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], d_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign lvl_o  = sr_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int                    NUM_REGS = 8,
  parameter int                    AW       = 3,
  parameter logic [NUM_REGS*8-1:0] RST_VAL  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    regs_o [NUM_REGS]
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_o[g] <= RST_VAL[g*8 +: 8];
      else if (we_i && (waddr_i == AW'(g)))       regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter int                    NUM_REGS = 8,
  parameter logic [6:0]            DEV_ADDR = 7'h69,
  parameter int                    SYNC_STG = 2,
  parameter logic [NUM_REGS*8-1:0] RST_VAL  = 64'h0F00_A53C_0081_FF07
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  import smb_pkg::*;

  localparam int         AW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  smb_sync #(.STAGES(SYNC_STG)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .lvl_o(scl_s), .prev_o(scl_p));
  smb_sync #(.STAGES(SYNC_STG)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .lvl_o(sda_s), .prev_o(sda_p));

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  smb_state_e    state_q;
  logic [3:0]    bit_q;
  logic [7:0]    rx_q;
  logic [6:0]    tx_q;
  logic          oe_q, cmd_ok_q, blk_q, rd_first_q, mack_q;
  logic [AW-1:0] off_q;
  logic [7:0]    idx_q, cnt_q, rd_ptr_q;

  logic [7:0]    regs_arr [NUM_REGS];
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          addr_hit, cmd_good;
  logic [7:0]    rd_idx, tx_src;

  assign addr_hit = (rx_q[7:1] == DEV_ADDR);
  assign cmd_good = (rx_q[6:5] == 2'b00) &&
                    (!rx_q[7] || ({3'b000, rx_q[4:0]} < NREG8));
  assign wr_en    = scl_fall && (bit_q == 4'd8) && (state_q == ST_WDAT) &&
                    (cnt_q != 8'd0) && (idx_q < NREG8);
  assign wr_addr  = idx_q[AW-1:0];
  assign rd_idx   = rd_ptr_q - 8'd1;

  // byte to put on the wire at the next read slot
  always_comb begin
    tx_src = 8'hFF;
    if (blk_q) begin
      if (rd_ptr_q == 8'd0)   tx_src = NREG8;
      else if (rd_idx < NREG8) tx_src = regs_arr[rd_idx[AW-1:0]];
    end else if (rd_ptr_q == 8'd0) begin
      tx_src = regs_arr[off_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      oe_q       <= 1'b0;
      cmd_ok_q   <= 1'b0;
      blk_q      <= 1'b0;
      rd_first_q <= 1'b0;
      mack_q     <= 1'b0;
      off_q      <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
      rd_ptr_q   <= '0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      oe_q     <= 1'b0;
      cmd_ok_q <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_q == 4'd8) begin
          bit_q  <= '0;
          mack_q <= ~sda_s;
        end else begin
          rx_q  <= {rx_q[6:0], sda_s};
          bit_q <= bit_q + 4'd1;
        end
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          // ninth clock: acknowledge slot
          oe_q <= 1'b0;
          case (state_q)
            ST_ADDR: begin
              if (addr_hit && !rx_q[0]) begin
                oe_q     <= 1'b1;
                cmd_ok_q <= 1'b0;
                state_q  <= ST_CMD;
              end else if (addr_hit && cmd_ok_q) begin
                oe_q       <= 1'b1;
                rd_first_q <= 1'b1;
                rd_ptr_q   <= '0;
                state_q    <= ST_RDAT;
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_CMD: begin
              if (cmd_good) begin
                oe_q     <= 1'b1;
                cmd_ok_q <= 1'b1;
                blk_q    <= ~rx_q[7];
                off_q    <= rx_q[AW-1:0];
                if (rx_q[7]) begin
                  idx_q   <= {3'b000, rx_q[4:0]};
                  cnt_q   <= 8'd1;
                  state_q <= ST_WDAT;
                end else begin
                  state_q <= ST_CNT;
                end
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_CNT: begin
              oe_q    <= 1'b1;
              cnt_q   <= rx_q;
              idx_q   <= '0;
              state_q <= ST_WDAT;
            end
            ST_WDAT: begin
              oe_q <= 1'b1;
              if (wr_en) begin
                idx_q <= idx_q + 8'd1;
                cnt_q <= cnt_q - 8'd1;
              end
            end
            default: ;
          endcase
        end else if (state_q == ST_RDAT) begin
          if (bit_q == 4'd0) begin
            if (rd_first_q || mack_q) begin
              tx_q       <= tx_src[6:0];
              oe_q       <= ~tx_src[7];
              rd_first_q <= 1'b0;
              if (rd_ptr_q != 8'hFF) rd_ptr_q <= rd_ptr_q + 8'd1;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_SKIP;
            end
          end else begin
            tx_q <= {tx_q[5:0], 1'b0};
            oe_q <= ~tx_q[6];
          end
        end else if (bit_q == 4'd0) begin
          oe_q <= 1'b0;
        end
      end
    end
  end

  smb_regfile #(.NUM_REGS(NUM_REGS), .AW(AW), .RST_VAL(RST_VAL)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en), .waddr_i(wr_addr),
    .wdata_i(rx_q), .regs_o(regs_arr));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = regs_arr[g];
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  wr_en,
  input smb_pkg::smb_state_e   state_q,
  input logic                  start_det,
  input logic                  stop_det
);
  import smb_pkg::*;

  // R8: slave pulls SDA low only during SCL low
  p_oe_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  // R6: every stored byte is acknowledged
  p_write_acked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> sda_oe_o);

  // R2: registers move only after an accepted write
  p_regs_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(wr_en));

  // R3: idle or ignoring means SDA released
  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_SKIP) |-> !sda_oe_o);

  // R8: start restarts address phase, stop returns to idle
  p_start_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state_q == ST_ADDR);

  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> state_q == ST_IDLE);
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .regs_o(regs_o), .wr_en(wr_en), .state_q(state_q),
  .start_det(start_det), .stop_det(stop_det));

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;
  localparam int          HALF = 10;
  localparam logic [63:0] DEF  = 64'h0F00_A53C_0081_FF07;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'h80, 8'h5A}, '{8'h83, 8'hC3}, '{8'h87, 8'h01},
    '{8'h85, 8'hFE}, '{8'h81, 8'h80}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_tb = 1'b1;
  logic        sda_tb = 1'b1;
  logic        sda_line;
  logic        sda_oe;
  logic [63:0] regs;
  logic [7:0]  exp_r [8];
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_tb & ~sda_oe;

  smb_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_tb), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs));

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = exp_r[i];
    return f;
  endfunction

  task automatic chk_regs(input string tag);
    chk(regs == exp_flat(), tag, regs, exp_flat());
  endtask

  task automatic bus_start();
    sda_tb = 1'b1; w(HALF);
    scl_tb = 1'b1; w(HALF);
    sda_tb = 1'b0; w(HALF);
    scl_tb = 1'b0; w(1);
  endtask

  task automatic bus_stop();
    sda_tb = 1'b0; w(HALF);
    scl_tb = 1'b1; w(HALF);
    sda_tb = 1'b1; w(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_tb = b[i]; w(HALF);
      scl_tb = 1'b1; w(HALF);
      scl_tb = 1'b0; w(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_tb = 1'b1; w(HALF);
    scl_tb = 1'b1; w(HALF/2);
    ack = ~sda_line; w(HALF/2);
    scl_tb = 1'b0; w(1);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_tb = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(HALF);
      scl_tb = 1'b1; w(HALF/2);
      b[i] = sda_line; w(HALF/2);
      scl_tb = 1'b0; w(1);
    end
    sda_tb = ~mack; w(HALF);
    scl_tb = 1'b1; w(HALF);
    scl_tb = 1'b0; w(1);
    sda_tb = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] adr, input logic [7:0] cmd,
                        input logic [7:0] dat, output logic a1,
                        output logic a2, output logic a3);
    bus_start();
    send_byte(adr, a1);
    send_byte(cmd, a2);
    send_byte(dat, a3);
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] cmd, output logic [7:0] d,
                        output logic a1, output logic a2, output logic a3);
    bus_start();
    send_byte(8'hD2, a1);
    send_byte(cmd, a2);
    bus_start();
    send_byte(8'hD3, a3);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic       a1, a2, a3;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) exp_r[i] = DEF[i*8 +: 8];

    w(5); rst_n = 1'b1; w(5);
    chk_regs("R1 reset defaults");
    chk(sda_oe == 1'b0, "R1 sda released at reset", sda_oe, 0);

    // R4 / R5 table: byte write then byte read back
    for (int k = 0; k < 5; k++) begin
      wr_txn(8'hD2, VECS[k].cmd, VECS[k].data, a1, a2, a3);
      chk(a1 && a2 && a3, "R4 byte write acks", {a1, a2, a3}, 3'b111);
      exp_r[VECS[k].cmd[2:0]] = VECS[k].data;
      chk_regs("R4 byte write stored");
      rd_txn(VECS[k].cmd, d, a1, a2, a3);
      chk(a1 && a2 && a3, "R5 byte read acks", {a1, a2, a3}, 3'b111);
      chk(d == VECS[k].data, "R5 byte read data", d, VECS[k].data);
    end

    // R2 wrong address
    wr_txn(8'hA4, 8'h82, 8'h33, a1, a2, a3);
    chk(!a1 && !a2 && !a3, "R2 foreign address nacked", {a1, a2, a3}, 3'b000);
    chk_regs("R2 foreign address no effect");

    // R3 chip-select bits nonzero, byte and block forms
    wr_txn(8'hD2, 8'hA2, 8'h99, a1, a2, a3);
    chk(a1 && !a2 && !a3, "R3 chip select nacked", {a1, a2, a3}, 3'b100);
    wr_txn(8'hD2, 8'h40, 8'h02, a1, a2, a3);
    chk(a1 && !a2 && !a3, "R3 block chip select nacked", {a1, a2, a3}, 3'b100);
    chk_regs("R3 chip select no effect");

    // R4 offset out of range
    wr_txn(8'hD2, 8'h88, 8'h77, a1, a2, a3);
    chk(a1 && !a2 && !a3, "R4 offset 8 nacked", {a1, a2, a3}, 3'b100);
    chk_regs("R4 offset 8 no effect");

    // R9 read with no command
    bus_start();
    send_byte(8'hD3, a1);
    bus_stop();
    chk(!a1, "R9 read without command nacked", a1, 0);

    // R6 block write, count 3, four data bytes
    begin
      logic all_ack;
      all_ack = 1'b1;
      bus_start();
      send_byte(8'hD2, a1); all_ack &= a1;
      send_byte(8'h00, a1); all_ack &= a1;
      send_byte(8'd3,  a1); all_ack &= a1;
      for (int i = 0; i < 4; i++) begin
        send_byte(8'h11 * 8'(i + 1), a1); all_ack &= a1;
        if (i < 3) exp_r[i] = 8'h11 * 8'(i + 1);
      end
      bus_stop();
      chk(all_ack, "R6 block write count 3 acks", all_ack, 1);
      chk_regs("R6 block write count 3 data");
    end

    // R6 block write, count 10 beyond register 7
    begin
      logic all_ack;
      all_ack = 1'b1;
      bus_start();
      send_byte(8'hD2, a1); all_ack &= a1;
      send_byte(8'h00, a1); all_ack &= a1;
      send_byte(8'd10, a1); all_ack &= a1;
      for (int i = 0; i < 10; i++) begin
        send_byte(8'hA0 + 8'(i), a1); all_ack &= a1;
        if (i < 8) exp_r[i] = 8'hA0 + 8'(i);
      end
      bus_stop();
      chk(all_ack, "R6 extra block bytes acked", all_ack, 1);
      chk_regs("R6 extra block bytes discarded");
    end

    // R6 early stop after two bytes
    bus_start();
    send_byte(8'hD2, a1);
    send_byte(8'h00, a1);
    send_byte(8'd8, a1);
    send_byte(8'hB0, a1);
    send_byte(8'hB1, a1);
    bus_stop();
    exp_r[0] = 8'hB0;
    exp_r[1] = 8'hB1;
    chk_regs("R6 early stop keeps bytes");

    // R7 block read
    begin
      logic [7:0] cnt;
      bus_start();
      send_byte(8'hD2, a1);
      send_byte(8'h00, a2);
      bus_start();
      send_byte(8'hD3, a3);
      chk(a1 && a2 && a3, "R7 block read acks", {a1, a2, a3}, 3'b111);
      recv_byte(1'b1, cnt);
      chk(cnt == 8'd8, "R7 block read count", cnt, 8);
      for (int i = 0; i < 8; i++) begin
        recv_byte(i < 7, d);
        chk(d == exp_r[i], "R7 block read data", d, exp_r[i]);
      end
      w(HALF);
      chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
      bus_stop();
    end

    // R8 stop in mid-byte writes nothing
    bus_start();
    send_byte(8'hD2, a1);
    send_byte(8'h82, a1);
    send_bits(8'h00, 4);
    bus_stop();
    chk_regs("R8 stop mid byte no write");

    // R8 start in mid-byte restarts address phase
    bus_start();
    send_byte(8'hD2, a1);
    send_bits(8'h80, 3);
    wr_txn(8'hD2, 8'h86, 8'h6C, a1, a2, a3);
    chk(a1 && a2 && a3, "R8 restart acks", {a1, a2, a3}, 3'b111);
    exp_r[6] = 8'h6C;
    chk_regs("R8 restart write stored");

    // R1 reset restores defaults
    rst_n = 1'b0; w(3); rst_n = 1'b1; w(3);
    for (int i = 0; i < 8; i++) exp_r[i] = DEF[i*8 +: 8];
    chk_regs("R1 defaults after second reset");

    report();
  end
endmodule